// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides what a single memory access may do to a translated page. It receives the protection fields of a page table entry, the two key bits of the segment the address fell in, the privilege state of the running code, two class-key mask registers and the kind of access (instruction fetch, data load or data store). From these it forms a read/write/execute permission set, decides whether the access is allowed, and, when it is not, builds a syndrome that says which check refused it.

Three restrictions are derived on their own and combined by a bitwise AND. The first is the basic page protection: a table lookup on a 3-bit protection code and the effective key. The second removes execute from pages marked no-execute or guarded. The third picks a 2-bit field out of each class-key mask register, indexed by a 5-bit class key from the entry. Each restriction has its own syndrome bit, so the fault handler can tell them apart. Fetching the entry and raising the exception are left to the surrounding logic.

A request is presented with a one-cycle strobe. The result appears on registered outputs in the next cycle, together with a one-cycle valid pulse, and holds until the next request.

Top module: `page_perm_eval`

## Requirements
- R1: The effective key is `seg_kp` when `req_user` is 1 and `seg_ks` when `req_user` is 0.
- R2: Permission bits are ordered {execute, write, read} (bit 2, bit 1, bit 0). The protection code is {`pte_pp_hi`, `pte_pp[1:0]`}. With effective key 0, codes 0, 1 and 2 give 3'b111, codes 3 and 6 give 3'b101, and codes 4, 5 and 7 give 3'b000.
- R3: With effective key 1, codes 0 and 6 give 3'b000, codes 1 and 3 give 3'b101, code 2 gives 3'b111, and codes 4, 5 and 7 give 3'b000.
- R4: When `pte_noexec` or `pte_guard` is 1, the execute bit of the result is 0 and read and write are untouched by that restriction.
- R5: With `ckey_en` at 1, the class-key field for key k is bits [63-2k:62-2k] of `amr_val`; its upper bit clears write and its lower bit clears read. With `ckey_en` at 0, `amr_val` and `iamr_val` have no effect.
- R6: With `ckey_en` and `newer_arch` both 1, bit 62-2k of `iamr_val` clears execute for class key k; with `newer_arch` at 0 the instruction mask has no effect.
- R7: `rsp_perm` is the AND of the three restrictions. Access code 0 is a fetch and needs execute, code 1 a load and needs read, code 2 a store and needs write, code 3 is handled as a load. `rsp_allow` is the needed bit of `rsp_perm` and `rsp_fault` is its inverse.
- R8: On a fetch fault, `rsp_fetch_syn` bit 0 is set if the no-execute/guard restriction removed execute; otherwise bit 1 is set if basic protection removed execute. Bit 2 is set if the class-key restriction removed execute. It is 0 for allowed accesses and for data accesses.
- R9: On a load or store fault, `rsp_data_syn` bit 0 is set if basic protection lacks the needed bit, bit 1 is set for a store, bit 2 is set if the class-key restriction lacks the needed bit. It is 0 for allowed accesses and for fetches.
- R10: After reset all outputs are 0. A request sampled at a rising edge with `req_valid` 1 drives its result and a one-cycle `rsp_valid` pulse at that edge; without a request the result outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| req_user | input | 1 | 1 when running unprivileged |
| seg_kp | input | 1 | Segment key used when unprivileged |
| seg_ks | input | 1 | Segment key used when privileged |
| pte_pp | input | 2 | Low protection bits of the entry |
| pte_pp_hi | input | 1 | High protection bit of the entry |
| pte_noexec | input | 1 | Entry no-execute bit |
| pte_guard | input | 1 | Entry guarded bit |
| pte_ckey | input | KEY_W (5) | Class key of the entry |
| amr_val | input | 2*2^KEY_W (64) | Data class-key mask register |
| iamr_val | input | 2*2^KEY_W (64) | Instruction class-key mask register |
| ckey_en | input | 1 | Enables class-key protection |
| newer_arch | input | 1 | Enables the instruction mask check |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_perm | output | 3 | Combined permissions {X,W,R} |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_fetch_syn | output | 3 | Fetch fault syndrome |
| rsp_data_syn | output | 3 | Data fault syndrome |

## Verification
On every cycle the assertions check the pulse timing of `rsp_valid`, that a no-execute or guarded entry never yields execute, that a disabled class-key check or an older architecture mode leaves the key mask open for the affected bits, that an allowed result carries the bit the access needed, and that syndromes appear only for the right access kind and only with a fault. The exact protection tables, the field position selected by each class key, the key selection by privilege and the priority between the no-execute and protection syndrome bits can only be shown by the bench, which sweeps every code under both keys and places mask patterns at the lowest, a middle and the highest key.

// File: rtl/pap_pkg.sv
package pap_pkg;

  localparam int PERM_W = 3;
  localparam int PB_R   = 0;
  localparam int PB_W   = 1;
  localparam int PB_X   = 2;

  typedef logic [PERM_W-1:0] perm_t;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'd0,
    ACC_LOAD     = 2'd1,
    ACC_STORE    = 2'd2,
    ACC_LOAD_ALT = 2'd3
  } acc_e;

  // Basic page protection table, indexed by effective key and 3-bit code.
  function automatic perm_t base_table(input logic key, input logic [2:0] code);
    perm_t p;
    p = '0;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: p = 3'b111;
        3'd3, 3'd6:       p = 3'b101;
        default:          p = 3'b000;
      endcase
    end else begin
      case (code)
        3'd1, 3'd3: p = 3'b101;
        3'd2:       p = 3'b111;
        default:    p = 3'b000;
      endcase
    end
    return p;
  endfunction

  // Which permission bit an access kind consumes.
  function automatic int unsigned need_idx(input acc_e a);
    case (a)
      ACC_FETCH: return PB_X;
      ACC_STORE: return PB_W;
      default:   return PB_R;
    endcase
  endfunction

  // Mask produced by a 2-bit data class-key field.
  function automatic perm_t data_key_mask(input logic [1:0] fld);
    perm_t m;
    m       = 3'b111;
    m[PB_W] = ~fld[1];
    m[PB_R] = ~fld[0];
    return m;
  endfunction

endpackage

// File: rtl/pap_base_prot.sv
module pap_base_prot
  import pap_pkg::*;
(
  input  logic       user,
  input  logic       key_user,
  input  logic       key_super,
  input  logic [1:0] pp_lo,
  input  logic       pp_hi,
  input  logic       noexec,
  input  logic       guard,
  output logic       eff_key,
  output perm_t      base_perm,
  output perm_t      nx_perm
);

  logic [2:0] code;

  assign eff_key   = user ? key_user : key_super;
  assign code      = {pp_hi, pp_lo};
  assign base_perm = base_table(eff_key, code);

  always_comb begin
    nx_perm = 3'b111;
    if (noexec || guard) nx_perm[PB_X] = 1'b0;
  end

endmodule

// File: rtl/pap_class_key.sv
module pap_class_key
  import pap_pkg::*;
#(
  parameter  int KEY_W  = 5,
  localparam int NKEYS  = 1 << KEY_W,
  localparam int MASK_W = 2 * NKEYS
) (
  input  logic [KEY_W-1:0]  ckey,
  input  logic [MASK_W-1:0] amr,
  input  logic [MASK_W-1:0] iamr,
  input  logic              en,
  input  logic              newer,
  output perm_t             key_perm
);

  logic [1:0]       amr_fld  [NKEYS];
  logic [NKEYS-1:0] iamr_lo;
  logic [NKEYS-1:0] iamr_hi;
  logic [1:0]       sel_fld;
  logic             sel_ix;
  logic             unused_iamr_hi;

  // Key k owns the field starting at bit 2*(NKEYS-1-k): key 0 sits at the top.
  for (genvar g = 0; g < NKEYS; g++) begin : g_fld
    localparam int BASE = 2 * (NKEYS - 1 - g);
    assign amr_fld[g] = amr[BASE +: 2];
    assign iamr_lo[g] = iamr[BASE];
    assign iamr_hi[g] = iamr[BASE + 1];
  end

  assign unused_iamr_hi = ^iamr_hi;
  assign sel_fld        = amr_fld[ckey];
  assign sel_ix         = iamr_lo[ckey];

  always_comb begin
    key_perm = 3'b111;
    if (en) begin
      key_perm = data_key_mask(sel_fld);
      if (newer && sel_ix) key_perm[PB_X] = 1'b0;
    end
  end

endmodule

// File: rtl/pap_fault_syn.sv
module pap_fault_syn
  import pap_pkg::*;
(
  input  acc_e       acc,
  input  perm_t      base_perm,
  input  perm_t      nx_perm,
  input  perm_t      key_perm,
  output perm_t      net_perm,
  output logic       allow,
  output logic       fault,
  output logic [2:0] fetch_syn,
  output logic [2:0] data_syn
);

  int unsigned need;

  assign need     = need_idx(acc);
  assign net_perm = base_perm & nx_perm & key_perm;
  assign allow    = net_perm[need];
  assign fault    = ~allow;

  always_comb begin
    fetch_syn = '0;
    data_syn  = '0;
    if (fault) begin
      if (acc == ACC_FETCH) begin
        // No-execute outranks basic protection; key is reported alongside.
        fetch_syn[0] = ~nx_perm[PB_X];
        fetch_syn[1] = nx_perm[PB_X] & ~base_perm[PB_X];
        fetch_syn[2] = ~key_perm[PB_X];
      end else begin
        data_syn[0] = ~base_perm[need];
        data_syn[1] = (acc == ACC_STORE);
        data_syn[2] = ~key_perm[need];
      end
    end
  end

endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import pap_pkg::*;
#(
  parameter  int KEY_W  = 5,
  localparam int MASK_W = 2 * (1 << KEY_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic              seg_kp,
  input  logic              seg_ks,
  input  logic [1:0]        pte_pp,
  input  logic              pte_pp_hi,
  input  logic              pte_noexec,
  input  logic              pte_guard,
  input  logic [KEY_W-1:0]  pte_ckey,
  input  logic [MASK_W-1:0] amr_val,
  input  logic [MASK_W-1:0] iamr_val,
  input  logic              ckey_en,
  input  logic              newer_arch,
  output logic              rsp_valid,
  output logic [2:0]        rsp_perm,
  output logic              rsp_allow,
  output logic              rsp_fault,
  output logic [2:0]        rsp_fetch_syn,
  output logic [2:0]        rsp_data_syn
);

  acc_e       acc;
  logic       eff_key;
  perm_t      base_perm;
  perm_t      nx_perm;
  perm_t      key_perm;
  perm_t      net_perm;
  logic       allow_c;
  logic       fault_c;
  logic [2:0] fsyn_c;
  logic [2:0] dsyn_c;

  assign acc = acc_e'(req_acc);

  pap_base_prot u_base (
    .user      (req_user),
    .key_user  (seg_kp),
    .key_super (seg_ks),
    .pp_lo     (pte_pp),
    .pp_hi     (pte_pp_hi),
    .noexec    (pte_noexec),
    .guard     (pte_guard),
    .eff_key   (eff_key),
    .base_perm (base_perm),
    .nx_perm   (nx_perm)
  );

  pap_class_key #(.KEY_W(KEY_W)) u_ckey (
    .ckey     (pte_ckey),
    .amr      (amr_val),
    .iamr     (iamr_val),
    .en       (ckey_en),
    .newer    (newer_arch),
    .key_perm (key_perm)
  );

  pap_fault_syn u_syn (
    .acc       (acc),
    .base_perm (base_perm),
    .nx_perm   (nx_perm),
    .key_perm  (key_perm),
    .net_perm  (net_perm),
    .allow     (allow_c),
    .fault     (fault_c),
    .fetch_syn (fsyn_c),
    .data_syn  (dsyn_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_perm      <= '0;
      rsp_allow     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_fetch_syn <= '0;
      rsp_data_syn  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_perm      <= net_perm;
        rsp_allow     <= allow_c;
        rsp_fault     <= fault_c;
        rsp_fetch_syn <= fsyn_c;
        rsp_data_syn  <= dsyn_c;
      end
    end
  end

endmodule

// File: rtl/pap_checker.sv
module pap_checker
  import pap_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_acc,
  input logic       pte_noexec,
  input logic       pte_guard,
  input logic       ckey_en,
  input logic       newer_arch,
  input logic [2:0] key_perm,
  input logic       rsp_valid,
  input logic [2:0] rsp_perm,
  input logic       rsp_allow,
  input logic       rsp_fault,
  input logic [2:0] rsp_fetch_syn,
  input logic [2:0] rsp_data_syn
);

  a_r10_pulse_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r10_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r4_nx_blocks_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (pte_noexec || pte_guard)) |=> !rsp_perm[PB_X]);

  a_r5_disabled_key_open: assert property (@(posedge clk) disable iff (!rst_n)
    !ckey_en |-> (key_perm == 3'b111));

  a_r6_older_mode_exec_open: assert property (@(posedge clk) disable iff (!rst_n)
    !newer_arch |-> key_perm[PB_X]);

  a_r7_allow_has_needed_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_allow) |-> rsp_perm[need_idx(acc_e'($past(req_acc)))]);

  a_r7_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> ((rsp_fetch_syn | rsp_data_syn) != 3'b000));

  a_r8_fetch_syn_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ($past(req_acc) != 2'd0)) |-> (rsp_fetch_syn == 3'b000));

  a_r8_nx_excludes_prot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fetch_syn[0] |-> !rsp_fetch_syn[1]);

  a_r9_store_bit_on_store_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data_syn[1]) |-> (rsp_fault && ($past(req_acc) == 2'd2)));

endmodule

bind page_perm_eval pap_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_acc       (req_acc),
  .pte_noexec    (pte_noexec),
  .pte_guard     (pte_guard),
  .ckey_en       (ckey_en),
  .newer_arch    (newer_arch),
  .key_perm      (key_perm),
  .rsp_valid     (rsp_valid),
  .rsp_perm      (rsp_perm),
  .rsp_allow     (rsp_allow),
  .rsp_fault     (rsp_fault),
  .rsp_fetch_syn (rsp_fetch_syn),
  .rsp_data_syn  (rsp_data_syn)
);

// File: tb/sim_page_perm_eval.sv
module sim_page_perm_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_acc = 2'd0;
  logic        req_user = 1'b0, seg_kp = 1'b0, seg_ks = 1'b0;
  logic [1:0]  pte_pp = 2'd0;
  logic        pte_pp_hi = 1'b0, pte_noexec = 1'b0, pte_guard = 1'b0;
  logic [4:0]  pte_ckey = 5'd0;
  logic [63:0] amr_val = '0, iamr_val = '0;
  logic        ckey_en = 1'b0, newer_arch = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_fault;
  logic [2:0]  rsp_perm, rsp_fetch_syn, rsp_data_syn;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string stim_tag = "R10";

  // Expected outputs, as registers of the behavioural model.
  logic [11:0] exp_vec = '0;
  string       exp_tag = "R10";

  always #2 clk = ~clk;

  page_perm_eval u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
    .req_user(req_user), .seg_kp(seg_kp), .seg_ks(seg_ks), .pte_pp(pte_pp),
    .pte_pp_hi(pte_pp_hi), .pte_noexec(pte_noexec), .pte_guard(pte_guard),
    .pte_ckey(pte_ckey), .amr_val(amr_val), .iamr_val(iamr_val),
    .ckey_en(ckey_en), .newer_arch(newer_arch), .rsp_valid(rsp_valid),
    .rsp_perm(rsp_perm), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_fetch_syn(rsp_fetch_syn), .rsp_data_syn(rsp_data_syn)
  );

  // Reference: returns {perm[2:0], allow, fault, fsyn[2:0], dsyn[2:0]}.
  function automatic logic [10:0] ref_eval();
    logic       k;
    int         c, pos, nb;
    logic [7:0] rd_ok, wr_ok;
    logic [2:0] base, nxm, keym, perm, fs, ds;
    logic       ok;
    k = req_user ? seg_kp : seg_ks;
    c = {pte_pp_hi, pte_pp};
    rd_ok = k ? 8'b0000_1110 : 8'b0100_1111;
    wr_ok = k ? 8'b0000_0100 : 8'b0000_0111;
    base = {rd_ok[c], wr_ok[c], rd_ok[c]};
    nxm  = (pte_noexec | pte_guard) ? 3'b011 : 3'b111;
    keym = 3'b111;
    if (ckey_en) begin
      pos = 62 - 2 * int'(pte_ckey);
      keym[1] = !amr_val[pos + 1];
      keym[0] = !amr_val[pos];
      if (newer_arch) keym[2] = !iamr_val[pos];
    end
    perm = base & nxm & keym;
    nb = (req_acc == 2'd0) ? 2 : (req_acc == 2'd2) ? 1 : 0;
    ok = perm[nb];
    fs = 3'b000;
    ds = 3'b000;
    if (!ok && req_acc == 2'd0) begin
      fs[0] = !nxm[2];
      fs[1] = nxm[2] && !base[2];
      fs[2] = !keym[2];
    end else if (!ok) begin
      ds[0] = !base[nb];
      ds[1] = (req_acc == 2'd2);
      ds[2] = !keym[nb];
    end
    return {perm, ok, !ok, fs, ds};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vec <= '0;
    end else begin
      exp_vec[11] <= req_valid;
      exp_tag     <= stim_tag;
      if (req_valid) exp_vec[10:0] <= ref_eval();
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      logic [11:0] got;
      got = {rsp_valid, rsp_perm, rsp_allow, rsp_fault, rsp_fetch_syn, rsp_data_syn};
      n_chk++;
      if (got !== exp_vec) begin
        n_bad++;
        $display("FAIL %s: got v=%b perm=%b ok=%b flt=%b fs=%b ds=%b exp v=%b perm=%b ok=%b flt=%b fs=%b ds=%b",
                 exp_tag, got[11], got[10:8], got[7], got[6], got[5:3], got[2:0],
                 exp_vec[11], exp_vec[10:8], exp_vec[7], exp_vec[6], exp_vec[5:3], exp_vec[2:0]);
      end
    end
  end

  task automatic send(input string tag, input logic [1:0] acc, input logic user,
                      input logic kp, input logic ks, input int code,
                      input logic nx, input logic gd, input logic [4:0] ck);
    @(negedge clk);
    stim_tag   = tag;
    req_valid  = 1'b1;
    req_acc    = acc;
    req_user   = user;
    seg_kp     = kp;
    seg_ks     = ks;
    {pte_pp_hi, pte_pp} = code[2:0];
    pte_noexec = nx;
    pte_guard  = gd;
    pte_ckey   = ck;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_acc   = 2'(i);
      pte_pp    = 2'(i + 1);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if ({rsp_valid, rsp_perm, rsp_allow, rsp_fault, rsp_fetch_syn, rsp_data_syn} !== 12'd0) begin
      n_bad++;
      $display("FAIL R10 reset: got %b expected 0",
               {rsp_valid, rsp_perm, rsp_allow, rsp_fault, rsp_fetch_syn, rsp_data_syn});
    end
    rst_n = 1'b1;
    checking = 1'b1;
    idle(2);

    // R2: key 0 table, every code and access kind
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 3; a++) send("R2", 2'(a), 1'b0, 1'b1, 1'b0, c, 1'b0, 1'b0, 5'd0);
    // R3: key 1 table
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 3; a++) send("R3", 2'(a), 1'b0, 1'b0, 1'b1, c, 1'b0, 1'b0, 5'd0);
    // R1: privilege picks the key
    for (int c = 0; c < 8; c++) begin
      send("R1", 2'd1, 1'b1, 1'b1, 1'b0, c, 1'b0, 1'b0, 5'd0);
      send("R1", 2'd2, 1'b1, 1'b0, 1'b1, c, 1'b0, 1'b0, 5'd0);
      send("R1", 2'd2, 1'b0, 1'b0, 1'b1, c, 1'b0, 1'b0, 5'd0);
    end
    // R4: no-execute / guarded
    for (int a = 0; a < 3; a++) begin
      send("R4", 2'(a), 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b0, 5'd0);
      send("R4", 2'(a), 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b1, 5'd0);
      send("R4", 2'(a), 1'b0, 1'b0, 1'b0, 3, 1'b1, 1'b1, 5'd0);
    end
    idle(3);

    // R5: data class-key fields at keys 0, 7 and 31
    amr_val = '0;
    amr_val[62 -: 0 + 1] = 1'b0;
    amr_val[63:62] = 2'b11;
    amr_val[49:48] = 2'b10;
    amr_val[1:0]   = 2'b01;
    amr_val[47:46] = 2'b01;
    ckey_en = 1'b1;
    foreach (amr_val[i]) if (i < 0) amr_val[i] = 1'b0;
    for (int k = 0; k < 32; k++)
      for (int a = 1; a < 3; a++) send("R5", 2'(a), 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'(k));
    ckey_en = 1'b0;
    for (int a = 0; a < 3; a++) begin
      send("R5", 2'(a), 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'd0);
      send("R5", 2'(a), 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'd7);
    end

    // R6: instruction mask only in newer mode with the check enabled
    amr_val  = '0;
    iamr_val = '0;
    iamr_val[62] = 1'b1;
    iamr_val[63 - 2 * 9] = 1'b1;
    iamr_val[62 - 2 * 9] = 1'b0;
    iamr_val[0]  = 1'b1;
    for (int m = 0; m < 4; m++) begin
      ckey_en    = m[0];
      newer_arch = m[1];
      for (int k = 0; k < 32; k += 9) send("R6", 2'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'(k));
      send("R6", 2'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'd31);
      send("R6", 2'd1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'd0);
    end

    // R8: fetch syndrome priority and key bit
    ckey_en = 1'b1;
    newer_arch = 1'b1;
    send("R8", 2'd0, 1'b0, 1'b0, 1'b0, 4, 1'b1, 1'b0, 5'd0);
    send("R8", 2'd0, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b0, 5'd0);
    send("R8", 2'd0, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b0, 5'd1);
    send("R8", 2'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b1, 5'd31);
    send("R8", 2'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'd31);
    send("R8", 2'd0, 1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0, 5'd1);
    // R9: data syndrome, including access code 3
    amr_val = '0;
    amr_val[63:62] = 2'b11;
    send("R9", 2'd2, 1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0, 5'd0);
    send("R9", 2'd2, 1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0, 5'd4);
    send("R9", 2'd1, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, 5'd0);
    send("R9", 2'd1, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, 5'd4);
    send("R9", 2'd3, 1'b0, 1'b0, 1'b0, 5, 1'b0, 1'b0, 5'd0);
    send("R9", 2'd3, 1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b1, 5'd2);
    send("R9", 2'd2, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b0, 5'd3);
    // R10: results hold across idle cycles, pulses are single
    send("R10", 2'd2, 1'b0, 1'b0, 1'b0, 7, 1'b0, 1'b0, 5'd0);
    idle(4);
    send("R10", 2'd1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 5'd5);
    idle(4);

    // R7: random mixture of everything
    for (int i = 0; i < 500; i++) begin
      amr_val    = {$urandom, $urandom};
      iamr_val   = {$urandom, $urandom};
      ckey_en    = 1'($urandom);
      newer_arch = 1'($urandom);
      send("R7", 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           int'($urandom_range(0, 7)), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) == 0), 5'($urandom));
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(3);
    done = 1'b1;
    summary();
  end

endmodule